// File: doc/BRIEF.md
# Slave Parallel Configuration Port

This block is the receive side of a synchronous parallel configuration bus. An external master drives an active-low chip select, an active-low write enable and a data bus that is 8 or 16 bits wide, chosen by a parameter. Each accepted beat is packed into a 32-bit word. A finished word goes to a downstream loader with a one-cycle valid strobe. The master may leave any number of idle cycles between beats.

The reset input is filtered by length. Only a low level held for a full window of clock edges restarts the port. A shorter dip leaves every register unchanged. After a valid reset the port stays deaf to the bus for a fixed blanking window and then starts accepting beats. A read access has no data path in this port, so it raises a one-cycle error pulse. When the loader reports that it is done, the port raises a sticky ready flag. From then on it ignores the bus until the next valid reset.

Top module: `cfg_slave_port`

## Requirements
- R1: A beat is captured at a rising edge only when `cs_n` and `we_n` are both sampled low at that edge, the port is in its running phase and `ready` is low.
- R2: Cycles with `cs_n` high, whatever the level of `we_n`, capture nothing and leave a partly assembled word intact.
- R3: With `BUS_W`=8, four beats make one word, first beat in bits 7:0 and last in bits 31:24. With `BUS_W`=16, two beats make one word, first beat in bits 15:0. `word_valid` is high for exactly the cycle after the edge that captured the last beat, and `word_data` holds the word during that cycle.
- R4: A reset counts only once `rst_n` has been sampled low at `RST_MIN` (50) consecutive edges. At that edge the port clears its partial word and drives `ready`, `word_valid` and `error` low.
- R5: A low pulse on `rst_n` that covers fewer than `RST_MIN` edges has no effect. A word in progress carries on, and `ready` keeps its level.
- R6: After a valid reset, the first `BLANK_CYC` (50) edges with `rst_n` sampled high capture no beat. A beat at the following edge is captured.
- R7: When `cs_n` is low and `we_n` is high in the running phase with `ready` low, a read access is detected. `error` goes high for exactly one cycle, the cycle after the first edge of each unbroken read access, however long that access lasts.
- R8: `ready` rises the cycle after `loader_done` is sampled high in the running phase. It then stays high until a valid reset, and a short reset pulse does not clear it.
- R9: While `ready` is high, beats and read accesses are ignored: no `word_valid` and no `error`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Active-low reset, accepted only after `RST_MIN` low edges |
| cs_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write enable |
| din | input | BUS_W | Beat data from the master |
| loader_done | input | 1 | Completion indication from the downstream loader |
| word_data | output | 32 | Assembled configuration word |
| word_valid | output | 1 | One-cycle strobe marking `word_data` valid |
| ready | output | 1 | Sticky configuration-complete flag |
| error | output | 1 | One-cycle pulse per detected read access |

## Verification
Every result is due one clock after the edge that causes it. `word_valid` follows the edge of the last beat, `error` follows the first edge of a read access, `ready` follows the edge that samples `loader_done`, and the cleared state follows the 50th low reset edge. The bench drives inputs at falling edges and reads outputs at the next falling edge, so each check lands half a cycle after the register that produces it. The blanking window is probed by driving junk beats on each of the 50 blanked edges and a real beat on the 51st. Any junk captured shows up as a wrong or extra word in the scoreboard. Two instances, one per bus width, share the same stimulus.

// File: rtl/cfg_slave_port.sv
module cfg_slave_port #(
  parameter int BUS_W     = 8,
  parameter int RST_MIN   = 50,
  parameter int BLANK_CYC = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             we_n,
  input  logic [BUS_W-1:0] din,
  input  logic             loader_done,
  output logic [31:0]      word_data,
  output logic             word_valid,
  output logic             ready,
  output logic             error
);
  localparam int BEATS = 32 / BUS_W;
  localparam int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int LO_W  = $clog2(RST_MIN + 1);
  localparam int BL_W  = $clog2(BLANK_CYC + 1);
  localparam int LOW_W = 32 - BUS_W;

  typedef enum logic [1:0] {S_HOLD = 2'd0, S_BLANK = 2'd1, S_RUN = 2'd2} phase_t;

  phase_t           phase;
  logic [LO_W-1:0]  lo_cnt;
  logic [BL_W-1:0]  bl_cnt;
  logic [IDX_W-1:0] idx;
  logic [31:0]      acc;
  logic             rd_prev;

  wire rst_take = !rst_n && (lo_cnt >= LO_W'(RST_MIN - 1));
  wire live     = (phase == S_RUN) && !ready;
  wire beat     = live && !cs_n && !we_n;
  wire rd       = live && !cs_n && we_n;
  wire last     = (idx == IDX_W'(BEATS - 1));

  always_ff @(posedge clk) begin
    if (rst_n)
      lo_cnt <= '0;
    else if (lo_cnt != LO_W'(RST_MIN))
      lo_cnt <= lo_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst_take) begin
      phase      <= S_HOLD;
      bl_cnt     <= '0;
      idx        <= '0;
      acc        <= '0;
      word_data  <= '0;
      word_valid <= 1'b0;
      ready      <= 1'b0;
      error      <= 1'b0;
      rd_prev    <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      error      <= rd && !rd_prev;
      rd_prev    <= rd;
      case (phase)
        S_HOLD: if (rst_n) begin
          phase  <= (BLANK_CYC <= 1) ? S_RUN : S_BLANK;
          bl_cnt <= BL_W'(1);
        end
        S_BLANK: begin
          bl_cnt <= bl_cnt + 1'b1;
          if (bl_cnt == BL_W'(BLANK_CYC - 1)) phase <= S_RUN;
        end
        default: if (loader_done) ready <= 1'b1;
      endcase
      if (beat) begin
        if (last) begin
          word_data  <= {din, acc[LOW_W-1:0]};
          word_valid <= 1'b1;
          idx        <= '0;
        end else begin
          acc[idx*BUS_W +: BUS_W] <= din;
          idx <= idx + 1'b1;
        end
      end
    end
  end

  assert_err_single_R7: assert property (@(posedge clk) disable iff (phase == S_HOLD)
    error |=> !error);
  assert_valid_after_beat_R1: assert property (@(posedge clk) disable iff (phase == S_HOLD)
    word_valid |-> $past(!cs_n && !we_n));
  assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (phase == S_HOLD)
    word_valid |=> !word_valid);
  assert_blank_quiet_R6: assert property (@(posedge clk) disable iff (phase == S_HOLD)
    (phase == S_BLANK) |=> !word_valid);
  assert_ready_cause_R8: assert property (@(posedge clk) disable iff (phase == S_HOLD)
    $rose(ready) |-> $past(loader_done));
  assert_ready_sticky_R8: assert property (@(posedge clk) disable iff (phase == S_HOLD)
    (ready && rst_n) |=> ready);
  assert_quiet_when_ready_R9: assert property (@(posedge clk) disable iff (phase == S_HOLD)
    (ready && $past(ready)) |=> (!word_valid && !error));
endmodule

// File: tb/cfg_slave_port_bench.sv
module cfg_slave_port_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b1, cs_n = 1'b1, we_n = 1'b1, done = 1'b0;
  logic [15:0] din = '0;
  logic [31:0] wd8, wd16;
  logic wv8, wv16, rdy8, rdy16, err8, err16;

  always #(CLK_P/2) clk = ~clk;

  cfg_slave_port #(.BUS_W(8)) u_cfg_slave_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .din(din[7:0]),
    .loader_done(done), .word_data(wd8), .word_valid(wv8), .ready(rdy8), .error(err8));
  cfg_slave_port #(.BUS_W(16)) u_cfg_slave_port_w16 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .din(din),
    .loader_done(done), .word_data(wd16), .word_valid(wv16), .ready(rdy16), .error(err16));

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  logic [31:0] q8[$], q16[$];
  logic [31:0] a8 = '0, a16 = '0;
  int n8 = 0, n16 = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    a8 = '0; a16 = '0; n8 = 0; n16 = 0;
  endtask

  task automatic put(logic [15:0] d, bit acc);
    @(negedge clk); cs_n = 1'b0; we_n = 1'b0; din = d;
    if (acc) begin
      a8[n8*8 +: 8] = d[7:0]; n8++;
      if (n8 == 4) begin q8.push_back(a8); a8 = '0; n8 = 0; end
      a16[n16*16 +: 16] = d; n16++;
      if (n16 == 2) begin q16.push_back(a16); a16 = '0; n16 = 0; end
    end
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk); cs_n = 1'b1; we_n = $urandom_range(0, 1) == 1; din = 16'($urandom);
    end
  endtask

  task automatic drop_rst(int n, bit blank_beat);
    @(negedge clk); rst_n = 1'b0; cs_n = 1'b1; we_n = 1'b1;
    repeat (n) @(negedge clk);
    rst_n = 1'b1;
    if (n >= 50) model_clear();
    if (blank_beat) begin cs_n = 1'b0; we_n = 1'b0; din = 16'hEEEE; end
  endtask

  task automatic rd_seq(int len, bit exp);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i > 0) begin
        chk("R7 err8 during read", err8, (i == 1) ? exp : 1'b0);
        chk("R7 err16 during read", err16, (i == 1) ? exp : 1'b0);
      end
      cs_n = 1'b0; we_n = 1'b1;
    end
    @(negedge clk);
    chk("R7 err8 after read", err8, (len == 1) ? exp : 1'b0);
    cs_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
    chk("R7 err8 pulse ended", err8, 1'b0);
    chk("R7 err16 pulse ended", err16, 1'b0);
  endtask

  always @(negedge clk) if (!finished) begin
    if (wv8) begin
      if (q8.size() == 0) begin checks++; fails++;
        $display("FAIL R3 unexpected 8-bit word actual=%h expected=none", wd8); end
      else chk("R3 8-bit word", wd8, q8.pop_front());
    end
    if (wv16) begin
      if (q16.size() == 0) begin checks++; fails++;
        $display("FAIL R3 unexpected 16-bit word actual=%h expected=none", wd16); end
      else chk("R3 16-bit word", wd16, q16.pop_front());
    end
  end

  initial begin
    repeat (CLK_P * 2000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1; checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(2);
    drop_rst(60, 1'b0);
    chk("R4 reset ready8", rdy8, 0); chk("R4 reset ready16", rdy16, 0);
    chk("R4 reset valid", wv8, 0); chk("R4 reset error", err8, 0);
    idle(49);
    // R1 R2 R3: words with random gaps, including cs_n high / we_n low cycles
    for (int b = 0; b < 16; b++) begin
      put(16'($urandom), 1'b1);
      idle($urandom_range(0, 3));
    end
    idle(3);
    // R5: short pulse in the middle of a word
    put(16'h1122, 1'b1); put(16'h3344, 1'b1);
    drop_rst(49, 1'b0);
    put(16'h5566, 1'b1); put(16'h7788, 1'b1);
    idle(3);
    // R7: long and single-cycle read accesses
    rd_seq(3, 1'b1);
    rd_seq(1, 1'b1);
    // R4 R6: partial word cleared, 50 blanked edges, capture on the 51st
    put(16'hABCD, 1'b1);
    drop_rst(50, 1'b1);
    for (int i = 0; i < 49; i++) put(16'hEEEE, 1'b0);
    put(16'h0102, 1'b1); put(16'h0304, 1'b1); put(16'h0506, 1'b1); put(16'h0708, 1'b1);
    idle(3);
    chk("R4 R6 words drained 8", q8.size(), 0);
    // R8: ready one cycle after done
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
    chk("R8 ready8 rises", rdy8, 1); chk("R8 ready16 rises", rdy16, 1);
    // R9: bus ignored once ready
    for (int i = 0; i < 8; i++) put(16'($urandom), 1'b0);
    rd_seq(2, 1'b0);
    chk("R9 ready kept", rdy8, 1);
    // R5 R8: short pulse keeps ready
    drop_rst(30, 1'b0);
    idle(2);
    chk("R5 ready after short pulse", rdy8, 1); chk("R8 ready16 short pulse", rdy16, 1);
    // R4: valid reset clears ready
    drop_rst(50, 1'b0);
    chk("R4 ready8 cleared", rdy8, 0); chk("R4 ready16 cleared", rdy16, 0);
    idle(5);
    chk("R3 queue8 empty", q8.size(), 0); chk("R3 queue16 empty", q16.size(), 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule